// File: doc/BRIEF.md
# Oldest-First Squash Request Arbiter

This block sits between the execution units of an out-of-order core and its commit stage. In any cycle, branch units may report mispredictions and the memory-ordering logic may report a load that ran ahead of a conflicting store. Each report names a thread, the sequence number of the offending instruction and the PC to restart from. The arbiter picks, for every hardware thread, the single request that commit must honour: the oldest one, which is the one with the smallest sequence number.

The ports are resolved in a fixed order within the cycle. Branch reports are taken first, in port order, and the violation reports follow. A branch only displaces the current choice when it is strictly older. A violation also displaces a choice of equal age. This handles the case where one load is both mispredicted and found to violate ordering. The violation must win, because the squash then has to remove the load itself and not only the instructions behind it. The winning choice for each thread is registered. The result is visible for exactly one cycle, and the next cycle starts from nothing pending.

Top module: `squash_arbiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output bit becomes 0 at that edge, whatever the request inputs carry.
- R2: Outputs are registered and hold only the requests of the previous cycle. A thread that had no request in that cycle shows `sq_valid`=0 and all of its other fields as 0.
- R3: A branch request replaces the current choice only when its sequence number is strictly smaller. When two branch ports carry the same sequence number for one thread, the lower-numbered port wins.
- R4: A violation request replaces the current choice when its sequence number is smaller than or equal to it. On a tie with a branch, the violation wins and `sq_self`=1.
- R5: A winning branch request yields `sq_valid`=1, `sq_seq` equal to its sequence number, `sq_taken` equal to its taken bit, `sq_pc` equal to its PC and `sq_self`=0.
- R6: A winning violation request yields `sq_valid`=1, `sq_seq` equal to its sequence number, `sq_pc` equal to its PC, `sq_taken`=0 and `sq_self`=1.
- R7: A request counts only for the thread named by its thread ID. Requests for one thread never change the outputs of another thread.
- R8: With several requests for a thread in one cycle, the winner has the smallest sequence number among them. Violations win ties, and the lowest branch port wins otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | NUM_BR | Branch mispredict request valid, one bit per port |
| br_tid | input | NUM_BR x TID_W | Thread ID of each branch request |
| br_seq | input | NUM_BR x SEQ_W | Sequence number of each branch request |
| br_taken | input | NUM_BR | Resolved taken bit of each branch request |
| br_pc | input | NUM_BR x PC_W | Corrected PC of each branch request |
| mv_valid | input | NUM_MV | Memory-order violation request valid, one bit per port |
| mv_tid | input | NUM_MV x TID_W | Thread ID of each violation request |
| mv_seq | input | NUM_MV x SEQ_W | Sequence number of the violating instruction |
| mv_pc | input | NUM_MV x PC_W | Restart PC of each violation request |
| sq_valid | output | NUM_THREADS | Squash requested for the thread |
| sq_seq | output | NUM_THREADS x SEQ_W | Winning sequence number per thread |
| sq_taken | output | NUM_THREADS | Branch-taken bit of the winner per thread |
| sq_pc | output | NUM_THREADS x PC_W | Redirect PC per thread |
| sq_self | output | NUM_THREADS | Squash includes the named instruction itself |

## Verification
The assertions assume that request inputs are idle while reset is applied. Those checks relate the outputs to the inputs of the cycle just after reset drops, so a request held during reset would look like a dropped request. They also assume unsigned sequence numbers that never wrap, so a smaller number is always an older instruction. The stimulus drives only the values 5, 6 and 7. It walks every combination of valid bits, thread IDs and those values over the two branch ports and the violation port, which reaches every tie and every cross-thread pairing. It applies reset only as a separate step, with requests deliberately active, to check that reset dominates.

// File: rtl/squash_arb_pkg.sv
package squash_arb_pkg;

  localparam int DEF_THREADS = 2;
  localparam int DEF_SEQ_W   = 16;
  localparam int DEF_PC_W    = 32;

  // True when a request of age req should displace the current choice cur.
  function automatic logic seq_displaces(input logic [63:0] req,
                                         input logic [63:0] cur,
                                         input logic        cur_valid,
                                         input logic        allow_equal);
    logic older;
    logic same;
    older = (req < cur);
    same  = (req == cur);
    return !cur_valid || older || (allow_equal && same);
  endfunction

endpackage

// File: rtl/squash_cand_step.sv
module squash_cand_step
  import squash_arb_pkg::*;
#(
  parameter int SEQ_W       = DEF_SEQ_W,
  parameter int PC_W        = DEF_PC_W,
  parameter bit ALLOW_EQUAL = 1'b0
) (
  input  logic             in_valid,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic             in_taken,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_self,
  input  logic             req_hit,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             req_taken,
  input  logic [PC_W-1:0]  req_pc,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  output logic             out_taken,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_self
);

  logic accept;

  always_comb begin
    accept = req_hit && seq_displaces(64'(req_seq), 64'(in_seq), in_valid, ALLOW_EQUAL);
    if (accept) begin
      out_valid = 1'b1;
      out_seq   = req_seq;
      out_taken = req_taken;
      out_pc    = req_pc;
      out_self  = ALLOW_EQUAL;
    end else begin
      out_valid = in_valid;
      out_seq   = in_seq;
      out_taken = in_taken;
      out_pc    = in_pc;
      out_self  = in_self;
    end
  end

endmodule

// File: rtl/squash_thread_resolve.sv
module squash_thread_resolve
  import squash_arb_pkg::*;
#(
  parameter int THREAD_ID = 0,
  parameter int NUM_BR    = 2,
  parameter int NUM_MV    = 1,
  parameter int TID_W     = 1,
  parameter int SEQ_W     = DEF_SEQ_W,
  parameter int PC_W      = DEF_PC_W
) (
  input  logic [NUM_BR-1:0]            br_valid,
  input  logic [NUM_BR-1:0][TID_W-1:0] br_tid,
  input  logic [NUM_BR-1:0][SEQ_W-1:0] br_seq,
  input  logic [NUM_BR-1:0]            br_taken,
  input  logic [NUM_BR-1:0][PC_W-1:0]  br_pc,
  input  logic [NUM_MV-1:0]            mv_valid,
  input  logic [NUM_MV-1:0][TID_W-1:0] mv_tid,
  input  logic [NUM_MV-1:0][SEQ_W-1:0] mv_seq,
  input  logic [NUM_MV-1:0][PC_W-1:0]  mv_pc,
  output logic                         win_valid,
  output logic [SEQ_W-1:0]             win_seq,
  output logic                         win_taken,
  output logic [PC_W-1:0]              win_pc,
  output logic                         win_self
);

  localparam int              STAGES = NUM_BR + NUM_MV;
  localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD_ID);

  logic             c_valid [STAGES+1];
  logic [SEQ_W-1:0] c_seq   [STAGES+1];
  logic             c_taken [STAGES+1];
  logic [PC_W-1:0]  c_pc    [STAGES+1];
  logic             c_self  [STAGES+1];

  assign c_valid[0] = 1'b0;
  assign c_seq[0]   = '0;
  assign c_taken[0] = 1'b0;
  assign c_pc[0]    = '0;
  assign c_self[0]  = 1'b0;

  // Branch ports first, in port order: only strictly older requests displace.
  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    squash_cand_step #(.SEQ_W(SEQ_W), .PC_W(PC_W), .ALLOW_EQUAL(1'b0)) u_step (
      .in_valid (c_valid[b]),
      .in_seq   (c_seq[b]),
      .in_taken (c_taken[b]),
      .in_pc    (c_pc[b]),
      .in_self  (c_self[b]),
      .req_hit  (br_valid[b] && (br_tid[b] == MY_TID)),
      .req_seq  (br_seq[b]),
      .req_taken(br_taken[b]),
      .req_pc   (br_pc[b]),
      .out_valid(c_valid[b+1]),
      .out_seq  (c_seq[b+1]),
      .out_taken(c_taken[b+1]),
      .out_pc   (c_pc[b+1]),
      .out_self (c_self[b+1])
    );
  end

  // Violation ports afterwards: equal age also displaces, so the violator is included.
  for (genvar m = 0; m < NUM_MV; m++) begin : g_mv
    squash_cand_step #(.SEQ_W(SEQ_W), .PC_W(PC_W), .ALLOW_EQUAL(1'b1)) u_step (
      .in_valid (c_valid[NUM_BR+m]),
      .in_seq   (c_seq[NUM_BR+m]),
      .in_taken (c_taken[NUM_BR+m]),
      .in_pc    (c_pc[NUM_BR+m]),
      .in_self  (c_self[NUM_BR+m]),
      .req_hit  (mv_valid[m] && (mv_tid[m] == MY_TID)),
      .req_seq  (mv_seq[m]),
      .req_taken(1'b0),
      .req_pc   (mv_pc[m]),
      .out_valid(c_valid[NUM_BR+m+1]),
      .out_seq  (c_seq[NUM_BR+m+1]),
      .out_taken(c_taken[NUM_BR+m+1]),
      .out_pc   (c_pc[NUM_BR+m+1]),
      .out_self (c_self[NUM_BR+m+1])
    );
  end

  assign win_valid = c_valid[STAGES];
  assign win_seq   = c_seq[STAGES];
  assign win_taken = c_taken[STAGES];
  assign win_pc    = c_pc[STAGES];
  assign win_self  = c_self[STAGES];

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
  import squash_arb_pkg::*;
#(
  parameter int NUM_THREADS = DEF_THREADS,
  parameter int NUM_BR      = 2,
  parameter int NUM_MV      = 1,
  parameter int SEQ_W       = DEF_SEQ_W,
  parameter int PC_W        = DEF_PC_W,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_BR-1:0]                 br_valid,
  input  logic [NUM_BR-1:0][TID_W-1:0]      br_tid,
  input  logic [NUM_BR-1:0][SEQ_W-1:0]      br_seq,
  input  logic [NUM_BR-1:0]                 br_taken,
  input  logic [NUM_BR-1:0][PC_W-1:0]       br_pc,
  input  logic [NUM_MV-1:0]                 mv_valid,
  input  logic [NUM_MV-1:0][TID_W-1:0]      mv_tid,
  input  logic [NUM_MV-1:0][SEQ_W-1:0]      mv_seq,
  input  logic [NUM_MV-1:0][PC_W-1:0]       mv_pc,
  output logic [NUM_THREADS-1:0]            sq_valid,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0] sq_seq,
  output logic [NUM_THREADS-1:0]            sq_taken,
  output logic [NUM_THREADS-1:0][PC_W-1:0]  sq_pc,
  output logic [NUM_THREADS-1:0]            sq_self
);

  logic             w_valid [NUM_THREADS];
  logic [SEQ_W-1:0] w_seq   [NUM_THREADS];
  logic             w_taken [NUM_THREADS];
  logic [PC_W-1:0]  w_pc    [NUM_THREADS];
  logic             w_self  [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    squash_thread_resolve #(
      .THREAD_ID(t), .NUM_BR(NUM_BR), .NUM_MV(NUM_MV),
      .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W)
    ) u_res (
      .br_valid (br_valid),
      .br_tid   (br_tid),
      .br_seq   (br_seq),
      .br_taken (br_taken),
      .br_pc    (br_pc),
      .mv_valid (mv_valid),
      .mv_tid   (mv_tid),
      .mv_seq   (mv_seq),
      .mv_pc    (mv_pc),
      .win_valid(w_valid[t]),
      .win_seq  (w_seq[t]),
      .win_taken(w_taken[t]),
      .win_pc   (w_pc[t]),
      .win_self (w_self[t])
    );
  end

  // One register stage; nothing carries over, so each cycle starts clean.
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid <= '0;
      sq_seq   <= '0;
      sq_taken <= '0;
      sq_pc    <= '0;
      sq_self  <= '0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        sq_valid[t] <= w_valid[t];
        sq_seq[t]   <= w_seq[t];
        sq_taken[t] <= w_taken[t];
        sq_pc[t]    <= w_pc[t];
        sq_self[t]  <= w_self[t];
      end
    end
  end

endmodule

// File: rtl/squash_arbiter_chk.sv
module squash_arbiter_chk #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_BR      = 2,
  parameter int NUM_MV      = 1,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 1
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_BR-1:0]                 br_valid,
  input logic [NUM_BR-1:0][TID_W-1:0]      br_tid,
  input logic [NUM_BR-1:0][SEQ_W-1:0]      br_seq,
  input logic [NUM_MV-1:0]                 mv_valid,
  input logic [NUM_MV-1:0][TID_W-1:0]      mv_tid,
  input logic [NUM_MV-1:0][SEQ_W-1:0]      mv_seq,
  input logic [NUM_THREADS-1:0]            sq_valid,
  input logic [NUM_THREADS-1:0][SEQ_W-1:0] sq_seq,
  input logic [NUM_THREADS-1:0]            sq_taken,
  input logic [NUM_THREADS-1:0]            sq_self
);

  logic [NUM_THREADS-1:0] req_seen;

  always_comb begin
    req_seen = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int b = 0; b < NUM_BR; b++)
        if (br_valid[b] && (32'(br_tid[b]) == t)) req_seen[t] = 1'b1;
      for (int m = 0; m < NUM_MV; m++)
        if (mv_valid[m] && (32'(mv_tid[m]) == t)) req_seen[t] = 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (sq_valid == '0) && (sq_self == '0) && (sq_taken == '0)); // R1

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    AST_IDLE_NO_SQUASH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(req_seen[t])) |-> !sq_valid[t]); // R2

    AST_TAKEN_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
      sq_taken[t] |-> (sq_valid[t] && !sq_self[t])); // R5

    AST_SELF_FROM_VIOL: assert property (@(posedge clk) disable iff (rst)
      sq_self[t] |-> (sq_valid[t] && $past(req_seen[t]))); // R6

    for (genvar b = 0; b < NUM_BR; b++) begin : g_b
      AST_BR_NOT_OLDER: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && br_valid[b] && (32'(br_tid[b]) == t)) |->
          (sq_valid[t] && (sq_seq[t] <= $past(br_seq[b])))); // R8
    end

    for (genvar m = 0; m < NUM_MV; m++) begin : g_m
      AST_VIOL_WINS_TIE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && mv_valid[m] && (32'(mv_tid[m]) == t)) |->
          (sq_valid[t] && (sq_self[t] ? (sq_seq[t] <= $past(mv_seq[m]))
                                      : (sq_seq[t] <  $past(mv_seq[m]))))); // R4
    end
  end

endmodule

bind squash_arbiter squash_arbiter_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_BR(NUM_BR), .NUM_MV(NUM_MV),
  .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst(rst),
  .br_valid(br_valid), .br_tid(br_tid), .br_seq(br_seq),
  .mv_valid(mv_valid), .mv_tid(mv_tid), .mv_seq(mv_seq),
  .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_taken(sq_taken), .sq_self(sq_self)
);

// File: tb/tb_squash_arbiter.sv
module tb_squash_arbiter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]             br_valid;
  logic [1:0][0:0]        br_tid;
  logic [1:0][15:0]       br_seq;
  logic [1:0]             br_taken;
  logic [1:0][31:0]       br_pc;
  logic [0:0]             mv_valid;
  logic [0:0][0:0]        mv_tid;
  logic [0:0][15:0]       mv_seq;
  logic [0:0][31:0]       mv_pc;
  logic [1:0]             sq_valid;
  logic [1:0][15:0]       sq_seq;
  logic [1:0]             sq_taken;
  logic [1:0][31:0]       sq_pc;
  logic [1:0]             sq_self;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  squash_arbiter dut (
    .clk(clk), .rst(rst),
    .br_valid(br_valid), .br_tid(br_tid), .br_seq(br_seq),
    .br_taken(br_taken), .br_pc(br_pc),
    .mv_valid(mv_valid), .mv_tid(mv_tid), .mv_seq(mv_seq), .mv_pc(mv_pc),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_taken(sq_taken),
    .sq_pc(sq_pc), .sq_self(sq_self)
  );

  task automatic idle_inputs();
    br_valid = '0; br_tid = '0; br_seq = '0; br_taken = '0; br_pc = '0;
    mv_valid = '0; mv_tid = '0; mv_seq = '0; mv_pc = '0;
  endtask

  // Packed {valid, seq, taken, pc, self} comparison for one thread.
  task automatic check_thread(input int t, input string tag,
                              input logic ev, input logic [15:0] es,
                              input logic et, input logic [31:0] ep,
                              input logic ef);
    logic [50:0] act, exp;
    act = {sq_valid[t], sq_seq[t], sq_taken[t], sq_pc[t], sq_self[t]};
    exp = {ev, es, et, ep, ef};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s thread %0d actual=%h expected=%h", tag, t, act, exp);
    end
  endtask

  // Expected winner per thread from the minimum-age rule, independent of port order chaining.
  task automatic check_case();
    for (int t = 0; t < 2; t++) begin
      int nreq = 0;
      int nother = 0;
      logic [15:0] mn = 16'hFFFF;
      logic ev = 1'b0, et = 1'b0, ef = 1'b0;
      logic [15:0] es = '0;
      logic [31:0] ep = '0;
      bit br_tie = 1'b0;
      bit br_at_min = 1'b0;
      string tag;
      for (int b = 0; b < 2; b++) begin
        if (br_valid[b] && int'(br_tid[b]) == t) begin nreq++; if (br_seq[b] < mn) mn = br_seq[b]; end
        else if (br_valid[b]) nother++;
      end
      if (mv_valid[0] && int'(mv_tid[0]) == t) begin nreq++; if (mv_seq[0] < mn) mn = mv_seq[0]; end
      else if (mv_valid[0]) nother++;
      if (nreq > 0) begin
        ev = 1'b1; es = mn;
        for (int b = 1; b >= 0; b--)
          if (br_valid[b] && int'(br_tid[b]) == t && br_seq[b] == mn) begin
            if (br_at_min) br_tie = 1'b1;
            br_at_min = 1'b1; et = br_taken[b]; ep = br_pc[b];
          end
        if (mv_valid[0] && int'(mv_tid[0]) == t && mv_seq[0] == mn) begin
          et = 1'b0; ep = mv_pc[0]; ef = 1'b1;
        end
      end
      if (nreq == 0)              tag = (nother > 0) ? "R7" : "R2";
      else if (ef && br_at_min)   tag = "R4";
      else if (!ef && br_tie)     tag = "R3";
      else if (nreq > 1)          tag = "R8";
      else if (ef)                tag = "R6";
      else                        tag = "R5";
      check_thread(t, tag, ev, es, et, ep, ef);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int idx;
    idle_inputs();
    repeat (3) @(posedge clk);
    #2;
    for (int t = 0; t < 2; t++) check_thread(t, "R1", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;

    idx = 0;
    for (int vm = 0; vm < 8; vm++)
      for (int tm = 0; tm < 8; tm++)
        for (int s0 = 5; s0 <= 7; s0++)
          for (int s1 = 5; s1 <= 7; s1++)
            for (int s2 = 5; s2 <= 7; s2++) begin
              @(negedge clk);
              br_valid = vm[1:0];
              mv_valid = vm[2];
              br_tid[0] = tm[0]; br_tid[1] = tm[1]; mv_tid[0] = tm[2];
              br_seq[0] = 16'(s0); br_seq[1] = 16'(s1); mv_seq[0] = 16'(s2);
              br_taken[0] = s0[0]; br_taken[1] = ~s1[0];
              br_pc[0] = 32'h1000_0000 + 32'(idx * 16);
              br_pc[1] = 32'h1000_0004 + 32'(idx * 16);
              mv_pc[0] = 32'h2000_0000 + 32'(idx * 16);
              @(posedge clk);
              #2;
              check_case();
              idx++;
            end

    // R2: a cycle with no requests clears what the previous cycle showed.
    @(negedge clk);
    idle_inputs();
    @(posedge clk);
    #2;
    for (int t = 0; t < 2; t++) check_thread(t, "R2", 0, 0, 0, 0, 0);

    // R1: reset dominates active requests on both threads.
    @(negedge clk);
    rst = 1'b1;
    br_valid = 2'b11; br_tid[0] = 1'b0; br_tid[1] = 1'b1;
    br_seq[0] = 16'd9; br_seq[1] = 16'd9; br_taken = 2'b11;
    mv_valid = 1'b1; mv_tid[0] = 1'b0; mv_seq[0] = 16'd3;
    @(posedge clk);
    #2;
    for (int t = 0; t < 2; t++) check_thread(t, "R1", 0, 0, 0, 0, 0);
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule